// File: doc/BRIEF.md
# Paged Address Translator with Writable Map

This block sits between an 8-bit CPU with a 16-bit address bus and a 512K physical memory. It divides the CPU's 64K logical space into 32 slots of 2K each. A table of 256 byte-wide entries decides which of the 256 physical 2K blocks each slot reaches. A three-bit context register selects one group of 32 entries. Switching context therefore swaps the whole logical map in one step.

An external controller programs the table. It raises a hold request, and the block answers by stalling the CPU through its wait output and by shutting off the memory enable. While hold is high, the controller can load a table pointer, write entries, read entries back and load the context. An entry write steps the pointer forward, so a run of consecutive entries needs one pointer load and then one write per entry. When hold falls, the CPU resumes and sees the new map. Translation is purely combinational, so the physical address settles in the same cycle as the logical address.

Top module: `pgmap_top`

## Requirements
- R1: physAddr[10:0] always equals cpuAddr[10:0].
- R2: physAddr[18:11] equals the table entry at index {context, cpuAddr[15:11]}, with the context in the three most significant index bits. It changes combinationally with cpuAddr.
- R3: After reset the context and the pointer are 0, and the entry at index {c, s} holds s for every context c and slot s. Every context is therefore an identity map of the low 64K.
- R4: memEn is 1 exactly when cpuMreqN is 0 and hostHold is 0.
- R5: cpuWaitN is 0 exactly while hostHold is 1.
- R6: With hostHold at 1, hostIdxWe at a clock edge loads the pointer from hostDin.
- R7: With hostHold at 1, hostDataWe at a clock edge stores hostDin in the entry the pointer selects. The pointer then advances by one, wrapping from 255 to 0.
- R8: hostDout always shows the entry the pointer selects, combinationally.
- R9: With hostHold at 1, hostCtxWe at a clock edge loads the context from hostDin[2:0].
- R10: With hostHold at 0, hostIdxWe, hostDataWe and hostCtxWe have no effect on the entries, the pointer or the context.
- R11: If hostIdxWe and hostDataWe are both 1 at one edge, the data goes to the old pointer position and the pointer takes the loaded value, with no advance.
- R12: Several slots may hold the same physical block number, and each of them then reaches that block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | 16 | CPU logical address |
| cpuMreqN | input | 1 | CPU memory request, active low |
| cpuWaitN | output | 1 | Stall to CPU, active low |
| memEn | output | 1 | Physical memory enable, active high |
| physAddr | output | 19 | Physical memory address |
| hostHold | input | 1 | Controller hold request |
| hostIdxWe | input | 1 | Load table pointer from hostDin |
| hostDataWe | input | 1 | Write entry at pointer and advance |
| hostCtxWe | input | 1 | Load context from hostDin[2:0] |
| hostDin | input | 8 | Controller write data |
| hostDout | output | 8 | Entry at current pointer |

## Verification
The assertions assume the controller changes the map only while the CPU is stalled. They also assume the CPU's address and request need no qualification beyond hold, because the block latches neither. The bench drives the CPU inputs freely in every phase. It raises hold before every programming burst, and it also drives the host strobes with hold low to test R10. All inputs change half a cycle away from the clock edge, so each strobe is seen at exactly one edge.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;

  // Strobes from the hold-gated control to the map datapath
  typedef struct packed {
    logic ldIdx;    // load table pointer
    logic wrEntry;  // write entry at pointer
    logic bumpIdx;  // advance pointer after a write
    logic ldCtx;    // load context register
  } hostStrb_t;

endpackage

// File: rtl/pgmap_ctrl.sv
module pgmap_ctrl
  import pgmap_pkg::*;
(
  input  logic      hostHold,
  input  logic      hostIdxWe,
  input  logic      hostDataWe,
  input  logic      hostCtxWe,
  input  logic      cpuMreqN,
  output hostStrb_t strb,
  output logic      memEn,
  output logic      cpuWaitN
);

  // Host strobes only count while the CPU is held off
  always_comb begin
    strb.ldIdx   = hostHold & hostIdxWe;
    strb.wrEntry = hostHold & hostDataWe;
    // a pointer load in the same cycle takes precedence over the advance
    strb.bumpIdx = hostHold & hostDataWe & ~hostIdxWe;
    strb.ldCtx   = hostHold & hostCtxWe;
  end

  // CPU side: stall while held, no memory cycle while held
  assign cpuWaitN = ~hostHold;
  assign memEn    = ~cpuMreqN & ~hostHold;

endmodule

// File: rtl/pgmap_dp.sv
module pgmap_dp
  import pgmap_pkg::*;
#(
  parameter int CTX_W  = 3,
  parameter int SLOT_W = 5,
  parameter int OFS_W  = 11,
  parameter int BLK_W  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  hostStrb_t               strb,
  input  logic [BLK_W-1:0]        hostDin,
  input  logic [SLOT_W+OFS_W-1:0] cpuAddr,
  output logic [BLK_W+OFS_W-1:0]  physAddr,
  output logic [BLK_W-1:0]        hostDout
);

  localparam int IDX_W = CTX_W + SLOT_W;
  localparam int DEPTH = 1 << IDX_W;
  localparam int SLOTS = 1 << SLOT_W;
  localparam int LA_W  = SLOT_W + OFS_W;

  // The pointer and the context are loaded from hostDin, so it must be wide enough
  initial begin
    if (IDX_W > BLK_W) $error("pointer wider than host data");
  end

  logic [BLK_W-1:0] mapMem [DEPTH];
  logic [IDX_W-1:0] idxQ;
  logic [CTX_W-1:0] ctxQ;
  logic [IDX_W-1:0] lookIdx;

  // Map entries: identity per context after reset
  for (genvar g = 0; g < DEPTH; g++) begin : gEntry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        mapMem[g] <= BLK_W'(g % SLOTS);
      else if (strb.wrEntry && idxQ == IDX_W'(g))
        mapMem[g] <= hostDin;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ <= '0;
      ctxQ <= '0;
    end else begin
      if (strb.ldIdx)        idxQ <= hostDin[IDX_W-1:0];
      else if (strb.bumpIdx) idxQ <= idxQ + 1'b1;
      if (strb.ldCtx)        ctxQ <= hostDin[CTX_W-1:0];
    end
  end

  // Combinational translation and readback
  assign lookIdx  = {ctxQ, cpuAddr[LA_W-1:OFS_W]};
  assign physAddr = {mapMem[lookIdx], cpuAddr[OFS_W-1:0]};
  assign hostDout = mapMem[idxQ];

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEntry && !strb.ldIdx) |=> idxQ == IDX_W'($past(idxQ) + 1'b1)); // R7

  AST_ENTRY_STORED: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEntry |=> mapMem[$past(idxQ)] == $past(hostDin)); // R7

  AST_IDX_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldIdx |=> idxQ == $past(hostDin[IDX_W-1:0])); // R11

  AST_CTX_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ldCtx |=> $stable(ctxQ)); // R9

endmodule

// File: rtl/pgmap_top.sv
module pgmap_top
  import pgmap_pkg::*;
#(
  parameter int CTX_W  = 3,
  parameter int SLOT_W = 5,
  parameter int OFS_W  = 11,
  parameter int BLK_W  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [SLOT_W+OFS_W-1:0] cpuAddr,
  input  logic                    cpuMreqN,
  output logic                    cpuWaitN,
  output logic                    memEn,
  output logic [BLK_W+OFS_W-1:0]  physAddr,
  input  logic                    hostHold,
  input  logic                    hostIdxWe,
  input  logic                    hostDataWe,
  input  logic                    hostCtxWe,
  input  logic [BLK_W-1:0]        hostDin,
  output logic [BLK_W-1:0]        hostDout
);

  hostStrb_t strb;

  pgmap_ctrl uCtrl (
    .hostHold   (hostHold),
    .hostIdxWe  (hostIdxWe),
    .hostDataWe (hostDataWe),
    .hostCtxWe  (hostCtxWe),
    .cpuMreqN   (cpuMreqN),
    .strb       (strb),
    .memEn      (memEn),
    .cpuWaitN   (cpuWaitN)
  );

  pgmap_dp #(
    .CTX_W  (CTX_W),
    .SLOT_W (SLOT_W),
    .OFS_W  (OFS_W),
    .BLK_W  (BLK_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .hostDin  (hostDin),
    .cpuAddr  (cpuAddr),
    .physAddr (physAddr),
    .hostDout (hostDout)
  );

  AST_MAP_FROZEN_RUN: assert property (@(posedge clk) disable iff (!rstN)
    !hostHold |=> $stable(hostDout)); // R10

  AST_NO_MEM_IN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (hostHold && !cpuWaitN) |-> !memEn); // R4

endmodule

// File: tb/sim_pgmap_top.sv
`timescale 1ns/1ps
module sim_pgmap_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic        cpuMreqN = 1'b1;
  logic        cpuWaitN, memEn;
  logic [18:0] physAddr;
  logic        hostHold = 1'b0, hostIdxWe = 1'b0, hostDataWe = 1'b0, hostCtxWe = 1'b0;
  logic [7:0]  hostDin = '0;
  logic [7:0]  hostDout;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference state
  int refMap [256];
  int refIdx = 0;
  int refCtx = 0;

  always #2 clk = ~clk;

  pgmap_top u0 (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuMreqN(cpuMreqN),
    .cpuWaitN(cpuWaitN), .memEn(memEn), .physAddr(physAddr),
    .hostHold(hostHold), .hostIdxWe(hostIdxWe), .hostDataWe(hostDataWe),
    .hostCtxWe(hostCtxWe), .hostDin(hostDin), .hostDout(hostDout)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Compare all outputs against the model, then advance one clock
  task automatic tick(string tag);
    int a, expPhys;
    #1;
    a = int'(cpuAddr);
    expPhys = (refMap[refCtx * 32 + (a >> 11)] << 11) | (a & 2047);
    chk({tag, " R1 low addr"}, int'(physAddr[10:0]), expPhys & 2047);
    chk({tag, " R2 block"}, int'(physAddr[18:11]), expPhys >> 11);
    chk({tag, " R4 memEn"}, int'(memEn), (!cpuMreqN && !hostHold) ? 1 : 0);
    chk({tag, " R5 wait"}, int'(cpuWaitN), hostHold ? 0 : 1);
    chk({tag, " R8 readback"}, int'(hostDout), refMap[refIdx]);
    @(posedge clk);
    if (rstN && hostHold) begin
      if (hostDataWe) refMap[refIdx] = int'(hostDin);
      if (hostIdxWe) refIdx = int'(hostDin);
      else if (hostDataWe) refIdx = (refIdx + 1) % 256;
      if (hostCtxWe) refCtx = int'(hostDin) & 7;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    hostIdxWe = 0; hostDataWe = 0; hostCtxWe = 0;
  endtask

  task automatic setIdx(int i, string tag);
    idle(); hostIdxWe = 1; hostDin = 8'(i); tick(tag); idle();
  endtask

  task automatic wrData(int v, string tag);
    idle(); hostDataWe = 1; hostDin = 8'(v); tick(tag); idle();
  endtask

  task automatic cpuSweep(string tag, int seed);
    for (int k = 0; k < 64; k++) begin
      cpuAddr  = 16'((k * 2048) + ((k * 97 + seed) & 2047));
      cpuMreqN = ((k + seed) % 3 == 0);
      tick(tag);
    end
    cpuAddr = 16'(32 * 2048 - 1); tick(tag);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) refMap[i] = i % 32;   // R3 identity model
    @(negedge clk);
    cpuMreqN = 0; cpuAddr = 16'h5a5a;
    tick("R3 in reset");
    tick("R3 in reset");
    rstN = 1;
    // R3: every entry reads back as identity, through the host port
    hostHold = 1;
    tick("R3 pointer zero");
    for (int i = 0; i < 256; i++) setIdx(i, "R3 sweep");
    tick("R3 last");

    // R6/R7: burst programming of context 0 with auto-advance
    setIdx(0, "R6 load");
    for (int i = 0; i < 32; i++) wrData((i * 37 + 5) & 255, "R7 burst");
    // R7 wrap from 255 to 0
    setIdx(254, "R6 load high");
    for (int i = 0; i < 3; i++) wrData(200 + i, "R7 wrap");
    tick("R7 after wrap");
    // R12 aliasing: two slots onto one block
    setIdx(3, "R12 ptr");  wrData(8'h77, "R12 slot3");
    setIdx(9, "R12 ptr");  wrData(8'h77, "R12 slot9");
    hostHold = 0;
    cpuAddr = 16'h1800 + 16'h0123; cpuMreqN = 0; tick("R12 slot3 read");
    cpuAddr = 16'h4800 + 16'h0456; tick("R12 slot9 read");
    cpuSweep("R1 R2 ctx0", 1);

    // R10: strobes with hold low do nothing
    hostIdxWe = 1; hostDataWe = 1; hostCtxWe = 1; hostDin = 8'hC6;
    for (int k = 0; k < 4; k++) tick("R10 ignored");
    idle();
    cpuSweep("R10 map kept", 2);

    // R9: new context, program and translate
    hostHold = 1;
    idle(); hostCtxWe = 1; hostDin = 8'h05; tick("R9 ctx load"); idle();
    setIdx(5 * 32, "R9 ptr");
    for (int i = 0; i < 32; i++) wrData(255 - i * 3, "R9 program");
    hostHold = 0;
    cpuSweep("R9 ctx5", 3);

    // R11: pointer load and data write in one cycle
    hostHold = 1;
    setIdx(5 * 32 + 7, "R11 ptr");
    idle(); hostIdxWe = 1; hostDataWe = 1; hostDin = 8'h42; tick("R11 both"); idle();
    tick("R11 ptr took load");
    setIdx(5 * 32 + 7, "R11 check old");
    tick("R11 old entry");
    hostHold = 0;
    cpuAddr = 16'(7 * 2048 + 3); tick("R11 translate");
    cpuSweep("R2 final", 4);

    done = 1;
    summary();
  end

endmodule